// File: doc/BRIEF.md
# Asynchronous Frame Receiver with Noise Rejection

This block turns an asynchronous serial line into parallel words. A strobe, one clock wide, arrives sixteen times per bit period. The block brings the raw line into the clock domain through a short synchronizer. It waits for a falling edge, then makes sure the start bit is still low at its midpoint. Each bit value is decided by a vote over three samples taken around the middle of the bit. The block collects 5 to 9 data bits, least significant bit first. If parity is enabled, it checks the parity bit, and it then checks the first stop bit.

A finished frame goes into a single receive buffer. The buffer carries a receive-complete flag and framing, parity and overrun error flags. Software empties the buffer by pulsing a read strobe. Multi-processor addressing mode is meant for 9-bit frames. In this mode the ninth bit marks a frame as an address, and frames without that mark are dropped silently. Software turns the mode off once its own address has been seen.

Top module: `arx_receiver`

## Requirements
- R1: After reset, `rx_done`, `err_frame`, `err_parity` and `err_overrun` are 0 and `rx_word` is all zeros.
- R2: The number of data bits is `cfg_data_bits` clamped to 5..9: values below 5 act as 5 and values above 9 act as 9. Bits arrive least significant bit first into `rx_word[0]` upward, and `rx_word` bits above the configured count read 0.
- R3: When `cfg_parity_en` is 1, one parity bit follows the data. `cfg_parity_odd` = 0 means an even count of ones over data plus parity, and 1 means an odd count. A mismatch sets `err_parity` for that frame. When parity is disabled, no parity bit is expected and `err_parity` is 0.
- R4: If the first stop bit is decided as 0, `err_frame` is set for that frame. The data is still delivered, and any further stop bits are not examined.
- R5: If the start bit is decided as 1 at its midpoint, the attempt is abandoned with no buffer change, and the receiver rearms for the next falling edge.
- R6: If a frame completes while `rx_done` is 1 and no read is strobed in that cycle, `err_overrun` is set. `rx_word`, `err_frame` and `err_parity` keep the unread frame's values.
- R7: A `rd_strobe` pulse clears `rx_done` and `err_overrun`. It leaves `rx_word`, `err_frame` and `err_parity` unchanged.
- R8: If a frame completes in the same cycle as `rd_strobe`, the new frame is buffered, `rx_done` stays 1, and `err_overrun` is 0.
- R9: Each bit value is the 2-of-3 majority of oversample ticks 7, 8 and 9 of 16 within the bit, so a single corrupted sample does not change the decided bit.
- R10: With `cfg_mp_mode` = 1, a frame whose bit 8 (the ninth data bit) is 0 is discarded. `rx_done`, `err_overrun` and the buffered values are not touched. A frame with bit 8 = 1 is buffered normally.
- R11: The framing and parity flags are replaced by the status of each newly buffered frame, so a clean frame clears an earlier error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Raw serial input, idle high |
| os_tick | input | 1 | One-clock strobe at 16 times the bit rate |
| cfg_data_bits | input | 4 | Requested data bits per frame (clamped to 5..9) |
| cfg_parity_en | input | 1 | Expect a parity bit after the data |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_mp_mode | input | 1 | Multi-processor filtering: keep only frames with bit 8 set |
| rd_strobe | input | 1 | Buffer read pulse |
| rx_word | output | 9 | Buffered data word |
| rx_done | output | 1 | Receive-complete flag |
| err_frame | output | 1 | Stop bit of the buffered frame was low |
| err_parity | output | 1 | Parity of the buffered frame mismatched |
| err_overrun | output | 1 | A frame was lost because the buffer was still unread |

## Verification
The risky overlap is a frame landing in the buffer in the same clock cycle that software strobes a read. In that case the read has to free the buffer for the new word, and no overrun may be reported. The bench leaves one frame unread. It then drives a second frame and raises the read strobe in the one cycle after the stop bit's ninth sample tick, which is the cycle the buffer loads. It judges the result by the new word in `rx_word`, `rx_done` still set and `err_overrun` clear. A separate case lets a frame land with no read at all, which must report an overrun and keep the old word.

// File: rtl/arx_pkg.sv
package arx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PARITY,
      RX_STOP
   } rx_phase_e;

   function automatic int unsigned clamp_width(input int unsigned req,
                                               input int unsigned lo,
                                               input int unsigned hi);
      if (req < lo) return lo;
      if (req > hi) return hi;
      return req;
   endfunction

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
   parameter int  STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("arx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/arx_bit_sampler.sv
module arx_bit_sampler
   import arx_pkg::*;
#(
   parameter int OS_RATE  = 16,
   parameter bit MAJORITY = 1'b1,
   localparam int CNT_W   = $clog2(OS_RATE + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             os_tick,
   input  logic             active,
   input  logic             line_s,
   input  logic [CNT_W-1:0] smp_idx,
   output logic             vote_valid,
   output logic             vote_bit
);
   localparam logic [CNT_W-1:0] TAP_LO  = CNT_W'(OS_RATE / 2 - 1);
   localparam logic [CNT_W-1:0] TAP_MID = CNT_W'(OS_RATE / 2);
   localparam logic [CNT_W-1:0] TAP_HI  = CNT_W'(OS_RATE / 2 + 1);

   logic take;
   assign take       = os_tick && active;
   assign vote_valid = take && (smp_idx == TAP_HI);

   logic s_mid;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          s_mid <= 1'b1;
      else if (take && smp_idx == TAP_MID) s_mid <= line_s;
   end

   generate
      if (MAJORITY) begin : g_vote3
         logic s_lo;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         s_lo <= 1'b1;
            else if (take && smp_idx == TAP_LO) s_lo <= line_s;
         end
         assign vote_bit = maj3(s_lo, s_mid, line_s);
      end else begin : g_vote1
         assign vote_bit = s_mid;
      end
   endgenerate
endmodule

// File: rtl/arx_frame_fsm.sv
module arx_frame_fsm
   import arx_pkg::*;
#(
   parameter int MAX_BITS = 9,
   parameter int MIN_BITS = 5,
   parameter int OS_RATE  = 16,
   localparam int CNT_W   = $clog2(OS_RATE + 1),
   localparam int IDX_W   = $clog2(MAX_BITS),
   localparam int CFG_W   = $clog2(MAX_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                os_tick,
   input  logic                line_s,
   input  logic [CFG_W-1:0]    cfg_bits,
   input  logic                par_en,
   input  logic                par_odd,
   input  logic                vote_valid,
   input  logic                vote_bit,
   output logic [CNT_W-1:0]    smp_idx,
   output logic                busy,
   output logic                frm_valid,
   output logic [MAX_BITS-1:0] frm_word,
   output logic                frm_perr,
   output logic                frm_ferr
);
   localparam logic [CNT_W-1:0] SMP_LAST = CNT_W'(OS_RATE);

   rx_phase_e           state;
   logic [CNT_W-1:0]    smp;
   logic [IDX_W-1:0]    bit_pos;
   logic [IDX_W-1:0]    last_pos;
   logic [MAX_BITS-1:0] shreg;
   logic                par_acc;
   logic                perr_q;
   int unsigned         nb_req;

   assign nb_req   = 32'(cfg_bits);
   assign last_pos = IDX_W'(clamp_width(nb_req, MIN_BITS, MAX_BITS) - 1);
   assign smp_idx  = smp + CNT_W'(1);
   assign busy     = (state != RX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         smp       <= '0;
         bit_pos   <= '0;
         shreg     <= '0;
         par_acc   <= 1'b0;
         perr_q    <= 1'b0;
         frm_valid <= 1'b0;
         frm_word  <= '0;
         frm_perr  <= 1'b0;
         frm_ferr  <= 1'b0;
      end else begin
         frm_valid <= 1'b0;
         if (os_tick) begin
            if (state == RX_IDLE) begin
               if (!line_s) begin
                  state   <= RX_START;
                  smp     <= CNT_W'(1);
                  bit_pos <= '0;
                  shreg   <= '0;
                  par_acc <= 1'b0;
                  perr_q  <= 1'b0;
               end
            end else begin
               smp <= (smp_idx == SMP_LAST) ? '0 : smp_idx;
               if (vote_valid) begin
                  case (state)
                     RX_START: begin
                        if (vote_bit) begin
                           state <= RX_IDLE;
                           smp   <= '0;
                        end else begin
                           state <= RX_DATA;
                        end
                     end
                     RX_DATA: begin
                        shreg[bit_pos] <= vote_bit;
                        par_acc        <= par_acc ^ vote_bit;
                        if (bit_pos == last_pos) state <= par_en ? RX_PARITY : RX_STOP;
                        else                     bit_pos <= bit_pos + 1'b1;
                     end
                     RX_PARITY: begin
                        perr_q <= par_acc ^ vote_bit ^ par_odd;
                        state  <= RX_STOP;
                     end
                     RX_STOP: begin
                        frm_valid <= 1'b1;
                        frm_word  <= shreg;
                        frm_perr  <= perr_q;
                        frm_ferr  <= ~vote_bit;
                        state     <= RX_IDLE;
                        smp       <= '0;
                     end
                     default: state <= RX_IDLE;
                  endcase
               end
            end
         end
      end
   end

   // R5: a start bit voted high sends the receiver back to waiting
   p_false_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_START && vote_valid && vote_bit) |=> (state == RX_IDLE))
      else $error("p_false_start_r5");

   // R4: frame completion is a single-cycle event
   p_frame_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> !frm_valid)
      else $error("p_frame_pulse_r4");

   // R9: the in-bit sample position never passes the last tick of a bit
   p_smp_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state != RX_IDLE) |-> (smp < SMP_LAST))
      else $error("p_smp_range_r9");
endmodule

// File: rtl/arx_rx_buffer.sv
module arx_rx_buffer #(
   parameter int MAX_BITS = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frm_valid,
   input  logic [MAX_BITS-1:0] frm_word,
   input  logic                frm_perr,
   input  logic                frm_ferr,
   input  logic                mp_mode,
   input  logic                rd_strobe,
   output logic [MAX_BITS-1:0] rx_word,
   output logic                rx_done,
   output logic                err_frame,
   output logic                err_parity,
   output logic                err_overrun
);
   logic drop, take, still_full;

   assign drop       = mp_mode && !frm_word[MAX_BITS-1];
   assign take       = frm_valid && !drop;
   assign still_full = rx_done && !rd_strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word     <= '0;
         rx_done     <= 1'b0;
         err_frame   <= 1'b0;
         err_parity  <= 1'b0;
         err_overrun <= 1'b0;
      end else if (take && still_full) begin
         err_overrun <= 1'b1;
      end else if (take) begin
         rx_word     <= frm_word;
         err_frame   <= frm_ferr;
         err_parity  <= frm_perr;
         rx_done     <= 1'b1;
         err_overrun <= 1'b0;
      end else if (rd_strobe) begin
         rx_done     <= 1'b0;
         err_overrun <= 1'b0;
      end
   end

   // R7: a read with no arriving frame empties the buffer
   p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !frm_valid) |=> (!rx_done && !err_overrun))
      else $error("p_read_clears_r7");

   // R6: an overrun can only be raised over an occupied buffer
   p_ovr_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_overrun) |-> $past(rx_done))
      else $error("p_ovr_needs_full_r6");

   // R10: filtered data frames leave the buffer untouched
   p_mp_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && mp_mode && !frm_word[MAX_BITS-1] && !rd_strobe)
      |=> ($stable(rx_done) && $stable(err_overrun) && $stable(rx_word)))
      else $error("p_mp_drop_r10");

   // R8: arrival together with a read keeps the buffer full, no overrun
   p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !drop && rd_strobe) |=> (rx_done && !err_overrun))
      else $error("p_collide_r8");
endmodule

// File: rtl/arx_receiver.sv
module arx_receiver
   import arx_pkg::*;
#(
   parameter int MAX_BITS    = 9,
   parameter int MIN_BITS    = 5,
   parameter int OS_RATE     = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit MAJORITY    = 1'b1,
   localparam int CFG_W      = $clog2(MAX_BITS + 1),
   localparam int CNT_W      = $clog2(OS_RATE + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_line,
   input  logic                os_tick,
   input  logic [CFG_W-1:0]    cfg_data_bits,
   input  logic                cfg_parity_en,
   input  logic                cfg_parity_odd,
   input  logic                cfg_mp_mode,
   input  logic                rd_strobe,
   output logic [MAX_BITS-1:0] rx_word,
   output logic                rx_done,
   output logic                err_frame,
   output logic                err_parity,
   output logic                err_overrun
);
   generate
      if (MIN_BITS < 1 || MAX_BITS < MIN_BITS || MAX_BITS > 15) begin : g_bad_bits
         $error("arx_receiver: data bit range out of bounds");
      end
      if (OS_RATE < 4 || (OS_RATE % 2) != 0) begin : g_bad_rate
         $error("arx_receiver: OS_RATE must be even and at least 4");
      end
   endgenerate

   logic                line_s;
   logic [CNT_W-1:0]    smp_idx;
   logic                busy;
   logic                vote_valid, vote_bit;
   logic                frm_valid, frm_perr, frm_ferr;
   logic [MAX_BITS-1:0] frm_word;

   arx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_line), .q(line_s)
   );

   arx_bit_sampler #(.OS_RATE(OS_RATE), .MAJORITY(MAJORITY)) u_sampler (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .active(busy),
      .line_s(line_s), .smp_idx(smp_idx),
      .vote_valid(vote_valid), .vote_bit(vote_bit)
   );

   arx_frame_fsm #(.MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .OS_RATE(OS_RATE)) u_fsm (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .line_s(line_s),
      .cfg_bits(cfg_data_bits), .par_en(cfg_parity_en), .par_odd(cfg_parity_odd),
      .vote_valid(vote_valid), .vote_bit(vote_bit),
      .smp_idx(smp_idx), .busy(busy),
      .frm_valid(frm_valid), .frm_word(frm_word),
      .frm_perr(frm_perr), .frm_ferr(frm_ferr)
   );

   arx_rx_buffer #(.MAX_BITS(MAX_BITS)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .frm_valid(frm_valid), .frm_word(frm_word),
      .frm_perr(frm_perr), .frm_ferr(frm_ferr),
      .mp_mode(cfg_mp_mode), .rd_strobe(rd_strobe),
      .rx_word(rx_word), .rx_done(rx_done),
      .err_frame(err_frame), .err_parity(err_parity),
      .err_overrun(err_overrun)
   );
endmodule

// File: tb/arx_receiver_tb.sv
module arx_receiver_tb;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       os_tick = 1'b0;
   logic [3:0] cfg_data_bits = 4'd8;
   logic       cfg_parity_en = 1'b0;
   logic       cfg_parity_odd = 1'b0;
   logic       cfg_mp_mode = 1'b0;
   logic       rd_strobe = 1'b0;
   logic [8:0] rx_word;
   logic       rx_done, err_frame, err_parity, err_overrun;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   arx_receiver u_dut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
      .cfg_data_bits(cfg_data_bits), .cfg_parity_en(cfg_parity_en),
      .cfg_parity_odd(cfg_parity_odd), .cfg_mp_mode(cfg_mp_mode),
      .rd_strobe(rd_strobe), .rx_word(rx_word), .rx_done(rx_done),
      .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one bit period: pat[i] is the line level seen at sample tick i+1
   task automatic drive_samples(input logic [15:0] pat, input bit rd_at9);
      for (int i = 0; i < 16; i++) begin
         rx_line = pat[i];
         repeat (3) @(negedge clk);
         os_tick = 1'b1;
         @(negedge clk);
         os_tick = 1'b0;
         if (rd_at9 && i == 8) begin
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
         end
      end
      rx_line = 1'b1;
   endtask

   task automatic send_frame(input logic [8:0] data, input int nb, input bit pflip,
                             input bit stop_low, input int gbit, input bit rd_at9);
      logic p;
      p = cfg_parity_odd;
      drive_samples(16'h0000, 1'b0);
      for (int b = 0; b < nb; b++) begin
         logic [15:0] pat;
         pat = {16{data[b]}};
         if (b == gbit) pat[7] = ~data[b];
         drive_samples(pat, 1'b0);
         p = p ^ data[b];
      end
      if (cfg_parity_en) drive_samples({16{p ^ pflip}}, 1'b0);
      drive_samples(stop_low ? 16'hFE00 : 16'hFFFF, rd_at9);
      drive_samples(16'hFFFF, 1'b0);
   endtask

   task automatic do_read();
      @(negedge clk) rd_strobe = 1'b1;
      @(negedge clk) rd_strobe = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 done", rx_done, 0);
      chk("R1 word", rx_word, 0);
      chk("R1 errors", {err_frame, err_parity, err_overrun}, 0);
   endtask

   task automatic t_basic8();
      cfg_data_bits = 4'd8;
      send_frame(9'h0A5, 8, 0, 0, -1, 0);
      chk("R2 word 8 bits", rx_word, 'h0A5);
      chk("R2 done", rx_done, 1);
      chk("R2 no errors", {err_frame, err_parity, err_overrun}, 0);
      do_read();
      chk("R7 done cleared", rx_done, 0);
      chk("R7 word kept", rx_word, 'h0A5);
   endtask

   task automatic t_widths();
      cfg_data_bits = 4'd5;
      send_frame(9'h1F5, 5, 0, 0, -1, 0);
      chk("R2 word 5 bits", rx_word, 'h015);
      do_read();
      cfg_data_bits = 4'd2;
      send_frame(9'h00A, 5, 0, 0, -1, 0);
      chk("R2 clamp low", rx_word, 'h00A);
      do_read();
      cfg_data_bits = 4'd9;
      send_frame(9'h1C3, 9, 0, 0, -1, 0);
      chk("R2 word 9 bits", rx_word, 'h1C3);
      do_read();
      cfg_data_bits = 4'd8;
   endtask

   task automatic t_parity();
      cfg_parity_en = 1'b1;
      cfg_parity_odd = 1'b0;
      send_frame(9'h03C, 8, 0, 0, -1, 0);
      chk("R3 even ok", err_parity, 0);
      chk("R3 word", rx_word, 'h03C);
      do_read();
      cfg_parity_odd = 1'b1;
      send_frame(9'h007, 8, 0, 0, -1, 0);
      chk("R3 odd ok", err_parity, 0);
      do_read();
      cfg_parity_odd = 1'b0;
      send_frame(9'h081, 8, 1, 0, -1, 0);
      chk("R3 even mismatch", err_parity, 1);
      do_read();
      chk("R7 parity flag kept on read", err_parity, 1);
      cfg_parity_en = 1'b0;
      send_frame(9'h066, 8, 0, 0, -1, 0);
      chk("R11 parity flag replaced", err_parity, 0);
      do_read();
   endtask

   task automatic t_framing();
      send_frame(9'h0C8, 8, 0, 1, -1, 0);
      chk("R4 framing flag", err_frame, 1);
      chk("R4 data delivered", rx_word, 'h0C8);
      do_read();
      send_frame(9'h0C9, 8, 0, 0, -1, 0);
      chk("R11 framing flag replaced", err_frame, 0);
      do_read();
   endtask

   task automatic t_false_start();
      drive_samples(16'hFFE0, 1'b0);
      drive_samples(16'hFFFF, 1'b0);
      drive_samples(16'hFFFF, 1'b0);
      chk("R5 no frame after false start", rx_done, 0);
      chk("R5 word untouched", rx_word, 'h0C9);
      send_frame(9'h05A, 8, 0, 0, -1, 0);
      chk("R5 rearmed", rx_word, 'h05A);
      do_read();
   endtask

   task automatic t_glitch();
      send_frame(9'h000, 8, 0, 0, 3, 0);
      chk("R9 glitch rejected low", rx_word, 'h000);
      do_read();
      send_frame(9'h0FF, 8, 0, 0, 6, 0);
      chk("R9 glitch rejected high", rx_word, 'h0FF);
      do_read();
   endtask

   task automatic t_overrun();
      send_frame(9'h011, 8, 0, 0, -1, 0);
      cfg_parity_en = 1'b1;
      send_frame(9'h022, 8, 1, 0, -1, 0);
      cfg_parity_en = 1'b0;
      chk("R6 overrun set", err_overrun, 1);
      chk("R6 old word kept", rx_word, 'h011);
      chk("R6 parity of lost frame ignored", err_parity, 0);
      do_read();
      chk("R7 overrun cleared", err_overrun, 0);
      chk("R7 done cleared after overrun", rx_done, 0);
   endtask

   task automatic t_collide();
      send_frame(9'h033, 8, 0, 0, -1, 0);
      send_frame(9'h044, 8, 0, 0, -1, 1);
      chk("R8 new word buffered", rx_word, 'h044);
      chk("R8 done held", rx_done, 1);
      chk("R8 no overrun", err_overrun, 0);
      do_read();
   endtask

   task automatic t_mp();
      cfg_data_bits = 4'd9;
      cfg_mp_mode = 1'b1;
      send_frame(9'h055, 9, 0, 0, -1, 0);
      chk("R10 data frame dropped", rx_done, 0);
      chk("R10 word untouched", rx_word, 'h044);
      send_frame(9'h1AA, 9, 0, 0, -1, 0);
      chk("R10 address accepted", rx_done, 1);
      chk("R10 address word", rx_word, 'h1AA);
      send_frame(9'h012, 9, 0, 0, -1, 0);
      chk("R10 dropped frame no overrun", err_overrun, 0);
      chk("R10 word kept", rx_word, 'h1AA);
      do_read();
      cfg_mp_mode = 1'b0;
      send_frame(9'h012, 9, 0, 0, -1, 0);
      chk("R10 mode off accepts data", rx_word, 'h012);
      do_read();
      cfg_data_bits = 4'd8;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      drive_samples(16'hFFFF, 1'b0);
      t_basic8();
      t_widths();
      t_parity();
      t_framing();
      t_false_start();
      t_glitch();
      t_overrun();
      t_collide();
      t_mp();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule